// File: doc/BRIEF.md
# Saturating Power-of-Two Clock Prescaler

This block slows a fast master clock by a power of two chosen at run time. A 4-bit code selects an exponent, and the block divides the master rate by two raised to that exponent. It gives two results from the same divider. The first is a one-cycle enable pulse, for logic that stays on the master clock. The second is a square-wave output at the divided rate.

Codes above the largest supported exponent do not wrap around. They are clamped, so the slowest setting is a safe ceiling. A code written in the middle of a divided period does not take effect at once. The current period finishes at the old ratio, and the new ratio starts at the next wrap of the counter, so the outputs never show a shortened or lengthened period.

Top module: `pow2_prescaler`

## Requirements
- R1: The 4-bit code `prescale_code` is read as an unsigned exponent e (the exponent is the code itself for codes 0 to 8). While a setting is held, consecutive `tick` pulses are exactly 2^e master cycles apart, so the divide ratio spans 1 to 256.
- R2: For e from 1 to 8, `div_out` is a square wave with period 2^e cycles. It is low for the first 2^(e-1) cycles of each period and high for the last 2^(e-1) cycles.
- R3: Every code from 9 through 15 behaves exactly like code 8, which divides by 256.
- R4: With e = 0 the rate is passed through undivided. `tick` stays high on every cycle, and `div_out` follows the master clock level: it is high in the high phase and low in the low phase.
- R5: `tick` is high for exactly one cycle per divided period, and only in the first cycle of a new period. After reset is released with exponent e, the first pulse appears right after the 2^e-th rising edge. For e of 1 or more, the pulse coincides with the falling transition of `div_out`.
- R6: Reset is synchronous and active low. While `rst_n` is low at a rising edge, `tick` and `div_out` go low and the counter returns to the start of a period. The code present during reset sets the exponent of the first period.
- R7: A code change made during a period has no effect until that period ends. The period in progress runs to its full length at the old ratio, and the new ratio applies from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prescale_code | input | 4 | Requested exponent code; codes above 8 are treated as 8 |
| tick | output | 1 | One-cycle enable pulse, once per divided period |
| div_out | output | 1 | Divided square-wave output |

## Verification
The bench steps through exponent 0, small exponents, exponent 8 and the saturating codes 9, 12 and 15. A decoder that wraps instead of clamping would give periods that are far too short for those codes. Codes are changed partway through a period. A design that switches the ratio at once would show a period length that is neither the old one nor the new one.

For exponent 0, the output level is checked in both phases of the clock, which catches a bypass that is really a divide-by-two. A mid-run reset is also applied, so that a stale counter or a pulse during reset is caught at the ports.

// File: rtl/pow2_pkg.sv
// Package: shared sizes and helper functions for the power-of-two prescaler.
// Assumes the largest exponent is at least 1 and the code field can hold it.
package pow2_pkg;
    localparam int CODE_W  = 4;
    localparam int MAX_EXP = 8;
    localparam int CNT_W   = MAX_EXP;
    localparam int EXP_W   = $clog2(MAX_EXP + 1);

    // Terminal count for a given exponent: 2^e - 1, held in CNT_W bits.
    function automatic logic [CNT_W-1:0] pow2_mask(input logic [EXP_W-1:0] e);
        logic [CNT_W:0] one_hot;
        logic [CNT_W:0] span;
        one_hot = (CNT_W+1)'(1) << e;
        span    = one_hot - (CNT_W+1)'(1);
        return span[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/pow2_exp_clamp.sv
// Module: turns the raw prescale code into an exponent in the range 0..MAX_EXP.
// Assumes: purely combinational, and every code above MAX_EXP saturates to MAX_EXP.
module pow2_exp_clamp #(
    parameter int CODE_W  = pow2_pkg::CODE_W,
    parameter int MAX_EXP = pow2_pkg::MAX_EXP,
    parameter int EXP_W   = pow2_pkg::EXP_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [EXP_W-1:0]  exp_o
);
    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(MAX_EXP);

    // Saturate the code at the largest supported exponent.
    always_comb begin
        if (code_i > TOP_CODE) exp_o = EXP_W'(MAX_EXP);
        else                   exp_o = EXP_W'(code_i);
    end
endmodule

// File: rtl/pow2_div_counter.sv
// Module: the period counter, the exponent in force, and the wrap pulse.
// Assumes: exp_next_i is already clamped. A new exponent is taken only at reset or
// at the counter wrap, so every period runs to its full length.
module pow2_div_counter #(
    parameter int MAX_EXP = pow2_pkg::MAX_EXP,
    parameter int CNT_W   = pow2_pkg::CNT_W,
    parameter int EXP_W   = pow2_pkg::EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_next_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [EXP_W-1:0] exp_o,
    output logic             tick_o,
    output logic             run_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [EXP_W-1:0] exp_q;
    logic             tick_q;
    logic             run_q;
    logic             term;

    // The current period ends when the counter reaches 2^e - 1.
    assign term = (cnt_q == pow2_pkg::pow2_mask(exp_q));

    // Advance the counter; at the wrap, restart it and take the new exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            exp_q  <= exp_next_i;
            tick_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            run_q  <= 1'b1;
            tick_q <= term;
            if (term) begin
                cnt_q <= '0;
                exp_q <= exp_next_i;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign exp_o  = exp_q;
    assign tick_o = tick_q;
    assign run_o  = run_q;

    // R1: the exponent in force never exceeds the largest supported value.
    a_r1_exp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q <= EXP_W'(MAX_EXP));
    // R5: the end of a period is followed by a pulse and a counter back at zero.
    a_r5_tick_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> (tick_q && cnt_q == '0));
    // R7: the exponent holds steady except right after a wrap.
    a_r7_exp_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        !term |=> $stable(exp_q));
    // R4: with exponent 0, a pulse is present on every cycle that follows.
    a_r4_bypass_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_q == '0) |=> tick_q);
endmodule

// File: rtl/pow2_out_select.sv
// Module: picks the divided square wave from the counter bit that the exponent selects.
// Assumes: tap 0 is the master clock itself, used as the undivided bypass. The
// output is held low until the counter has left reset.
module pow2_out_select #(
    parameter int MAX_EXP = pow2_pkg::MAX_EXP,
    parameter int CNT_W   = pow2_pkg::CNT_W,
    parameter int EXP_W   = pow2_pkg::EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             div_o
);
    logic [MAX_EXP:0] tap;

    assign tap[0] = clk;
    // Tap e is counter bit e-1, which is low for the first half of a 2^e period.
    for (genvar i = 1; i <= MAX_EXP; i++) begin : g_tap
        assign tap[i] = cnt_i[i-1];
    end

    // Select the tap for the exponent in force, gated until the counter runs.
    always_comb div_o = run_i & tap[exp_i];

    // R2: with a nonzero exponent, the output is low at the start of every period.
    a_r2_low_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && exp_i != '0 && cnt_i == '0) |-> !div_o);
endmodule

// File: rtl/pow2_prescaler.sv
// Module: top of the saturating power-of-two prescaler. It gives a one-cycle
// enable pulse and a square wave at the master rate divided by 2^exponent.
// Assumes: a single clock domain and a synchronous active-low reset.
module pow2_prescaler #(
    parameter int CODE_W  = pow2_pkg::CODE_W,
    parameter int MAX_EXP = pow2_pkg::MAX_EXP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] prescale_code,
    output logic              tick,
    output logic              div_out
);
    localparam int CNT_W = MAX_EXP;
    localparam int EXP_W = $clog2(MAX_EXP + 1);

    logic [EXP_W-1:0] exp_next;
    logic [EXP_W-1:0] exp_now;
    logic [CNT_W-1:0] cnt;
    logic             run;

    pow2_exp_clamp #(.CODE_W(CODE_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_clamp (
        .code_i (prescale_code),
        .exp_o  (exp_next)
    );

    pow2_div_counter #(.MAX_EXP(MAX_EXP), .CNT_W(CNT_W), .EXP_W(EXP_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .exp_next_i (exp_next),
        .cnt_o      (cnt),
        .exp_o      (exp_now),
        .tick_o     (tick),
        .run_o      (run)
    );

    pow2_out_select #(.MAX_EXP(MAX_EXP), .CNT_W(CNT_W), .EXP_W(EXP_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .exp_i (exp_now),
        .cnt_i (cnt),
        .div_o (div_out)
    );
endmodule

// File: tb/sim_pow2_prescaler.sv
module sim_pow2_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code = 4'd3;
    logic       tick;
    logic       div_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    int  m_cnt = 0;
    int  m_exp = 0;
    bit  m_tick = 0;
    bit  m_run = 0;
    bit  m_sat = 0;
    bit  m_chg = 0;
    int  done_period = 0;
    bit  done_chg = 0;
    int  gap = 0;
    bit  gap_valid = 0;

    pow2_prescaler u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .prescale_code (code),
        .tick          (tick),
        .div_out       (div_out)
    );

    always #5 clk = ~clk;

    function automatic int clamp_code(input int c);
        return (c > 8) ? 8 : c;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    function automatic string out_tag();
        if (!m_run) return "R6";
        if (m_exp == 0) return "R4";
        if (m_sat) return "R3";
        return "R2";
    endfunction

    function automatic int exp_out(input bit high_phase);
        if (!m_run) return 0;
        if (m_exp == 0) return high_phase ? 1 : 0;
        return (m_cnt >> (m_exp - 1)) & 1;
    endfunction

    // Reference model: advanced on every rising edge from the pre-edge state.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_exp = clamp_code(code); m_sat = (code > 8);
            m_tick = 0; m_run = 0; m_chg = 0; gap_valid = 0; gap = 0;
        end else begin
            m_run = 1;
            m_tick = (m_cnt == (1 << m_exp) - 1);
            if (m_tick) begin
                done_period = 1 << m_exp;
                done_chg = m_chg;
                m_chg = 0;
                m_cnt = 0;
                m_exp = clamp_code(code);
                m_sat = (code > 8);
            end else begin
                m_cnt++;
            end
        end
        #2;
        check((m_exp == 0) ? "R4" : "R5", tick, m_tick);
        check(out_tag(), div_out, exp_out(1'b1));
        // Pulse spacing: R1, or R7 when the code moved during the period.
        if (m_run) begin
            gap++;
            if (tick) begin
                if (gap_valid) check(done_chg ? "R7" : (m_sat ? "R3" : "R1"), gap, done_period);
                gap = 0;
                gap_valid = 1;
            end
        end
    end

    // Low-phase output check; this is where a fake bypass shows up under R4.
    always @(negedge clk) begin
        #2;
        check(out_tag(), div_out, exp_out(1'b0));
    end

    task automatic set_code(input int c);
        @(negedge clk);
        if (code != 4'(c)) m_chg = 1;
        code = 4'(c);
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R6: reset state, with exponent 3 sampled during reset.
        run_cycles(3);
        check("R6", tick, 0);
        check("R6", div_out, 0);
        @(negedge clk) rst_n = 1'b1;
        run_cycles(40);
        set_code(0);  run_cycles(20);    // R4: bypass
        set_code(1);  run_cycles(20);
        set_code(8);  run_cycles(600);
        set_code(12); run_cycles(600);   // R3: saturating codes
        set_code(15); run_cycles(300);
        set_code(9);  run_cycles(300);
        set_code(5);  run_cycles(70);
        set_code(2);  run_cycles(3);     // R7: change mid-period
        set_code(6);  run_cycles(150);
        set_code(4);  run_cycles(9);
        @(negedge clk) rst_n = 1'b0;     // R6: mid-run reset
        run_cycles(2);
        check("R6", tick, 0);
        check("R6", div_out, 0);
        set_code(13);
        @(negedge clk) rst_n = 1'b1;
        run_cycles(600);
        set_code(0); run_cycles(10);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule